// File: doc/BRIEF.md
# Sequential Address Pointer Controller

This block keeps the 13-bit word address used by the sequential port of an 8K-word memory. Each clock the pointer either holds, steps forward by one, jumps to one of two buffer start addresses that the system has already set up, or takes an address from the 16-bit data input. A jump to a buffer start takes effect at the edge where its strobe is sampled. A load from the data input is done in two stages. The low 13 bits go into a data-in register at the first edge, and the pointer takes that register's value at the following edge. While the bus load is in progress, counting is frozen.

The block also reports when the addressed read data is usable, through `data_ready`. It raises `viol` for one cycle when the strobes are used against the protocol. The protocol forbids a buffer strobe during a bus load or in the cycle after it, two buffer strobes together, a repeated load strobe at the second stage, and a bus load whose three top data bits are not all ones. An end-of-buffer hook is provided: when it is enabled and the pointer steps from a chosen end address, the pointer returns to the buffer-1 start address instead of incrementing.

Top module: `sap_pointer_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pointer, the data-in register and the pending-load state clear to zero, and `data_ready` and `viol` read 0 after that edge.
- R2: With `load_n` high and no bus load pending, `strt1_n` low at an edge sets `ptr` to `start1` after that edge.
- R3: With `load_n` and `strt1_n` high and no bus load pending, `strt2_n` low at an edge sets `ptr` to `start2` after that edge.
- R4: `load_n` low at edge k with no bus load pending captures `din[12:0]`. `ptr` is unchanged after edge k and equals the captured value after edge k+1. `cnt_en` has no effect at either edge.
- R5: With no strobe low and no bus load pending, `cnt_en` high adds one to `ptr` per edge, wrapping from 8191 to 0. With `cnt_en` low, `ptr` holds.
- R6: `data_ready` is 0 after an edge at which `load_n` was low. It is 1 after any other edge with `rst_n` high, so it is 1 again one edge after a bus load lands.
- R7: A buffer strobe low at an edge where `load_n` is low, or at the edge after one, gives `viol` = 1 after that edge. The bus load still wins, and the pointer ignores the strobe.
- R8: At an edge with `load_n` low and `din[15:13]` not equal to 3'b111, `viol` is 1 after that edge. The address still loads from `din[12:0]`.
- R9: `strt1_n` and `strt2_n` low together load `start1` (buffer 1 has priority) and give `viol` = 1 after that edge.
- R10: With `eob_en` high, counting enabled and `ptr` equal to `eob_addr`, the next edge sets `ptr` to `start1`. With `eob_en` low, the pointer counts past `eob_addr`.
- R11: `load_n` low again at the second stage of a bus load gives `viol` = 1. The pointer takes the first captured value, the new value is captured, and the new value lands at the next edge.
- R12: With no violation at an edge, `viol` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Bus-load strobe, active low |
| strt1_n | input | 1 | Buffer-1 start strobe, active low |
| strt2_n | input | 1 | Buffer-2 start strobe, active low |
| cnt_en | input | 1 | Count enable |
| din | input | 16 | Data input; bits 12:0 carry the address |
| start1 | input | 13 | Preloaded buffer-1 start address |
| start2 | input | 13 | Preloaded buffer-2 start address |
| eob_en | input | 1 | Enables the end-of-buffer return |
| eob_addr | input | 13 | End-of-buffer address |
| ptr | output | 13 | Current address pointer |
| data_ready | output | 1 | Read data for the current pointer is usable |
| viol | output | 1 | Protocol violation seen at the previous edge |

## Verification
The bench aims at the two-stage bus load. A design that moves the pointer at the capture edge would show the new address one cycle early. A design that keeps counting during the load would land on a value one or two too high. The bench also drives a strobe inside the load window: a design that let the strobe win would show a start address where the loaded value belongs. A repeated load strobe is tested to catch a pointer that never lands on the first value. The bench also covers the 8191-to-0 wrap, both strobes together (a wrong priority loads `start2`), the three high data bits that must only flag (a design that loaded them, or skipped the flag, shows a wrong `ptr` or a missing `viol`), and the end-of-buffer return with the hook enabled and disabled.

// File: rtl/sap_pkg.sv
// Shared types for the sequential address pointer controller.
// Assumes: nothing beyond SystemVerilog 2017; widths live in the modules.
package sap_pkg;

    // Source that feeds the address pointer at the next edge
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_DIN  = 3'd1,
        SRC_BUF1 = 3'd2,
        SRC_BUF2 = 3'd3,
        SRC_INC  = 3'd4,
        SRC_EOB  = 3'd5
    } ptr_src_e;

endpackage

// File: rtl/sap_load_stage.sv
// First stage of a bus load: captures the address bits into the data-in
// register, remembers that a load is pending for one cycle, and produces the
// data-ready indication.
// Assumes: load_n is sampled on every rising edge; reset is synchronous.
module sap_load_stage #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] din_addr,
    output logic [ADDR_W-1:0] din_reg,
    output logic              pend,
    output logic              ready
);

    // Capture register and pending flag for the two-stage load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_reg <= '0;
            pend    <= 1'b0;
        end else begin
            pend <= ~load_n;
            if (!load_n) begin
                din_reg <= din_addr;
            end
        end
    end

    // Read data is unusable in the cycle after a capture edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else begin
            ready <= load_n;
        end
    end

endmodule

// File: rtl/sap_src_select.sv
// Chooses where the pointer comes from at the next edge.
// Priority: pending load landing, load capture (hold), buffer 1, buffer 2,
// then counting (with the end-of-buffer return), else hold.
// Assumes: pure combinational logic, and all inputs are synchronous.
module sap_src_select
    import sap_pkg::*;
(
    input  logic     load_n,
    input  logic     pend,
    input  logic     strt1_n,
    input  logic     strt2_n,
    input  logic     cnt_en,
    input  logic     eob_hit,
    output ptr_src_e src
);

    // Priority decode of the pointer source
    always_comb begin
        if (pend) begin
            src = SRC_DIN;
        end else if (!load_n) begin
            src = SRC_HOLD;
        end else if (!strt1_n) begin
            src = SRC_BUF1;
        end else if (!strt2_n) begin
            src = SRC_BUF2;
        end else if (cnt_en) begin
            src = eob_hit ? SRC_EOB : SRC_INC;
        end else begin
            src = SRC_HOLD;
        end
    end

endmodule

// File: rtl/sap_proto_check.sv
// Watches the strobes for protocol misuse and raises a one-cycle flag after
// the edge at which misuse was sampled.
// Assumes: DATA_W > ADDR_W; the bits above the address must be all ones
// during a bus load.
module sap_proto_check #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_n,
    input  logic                     pend,
    input  logic                     strt1_n,
    input  logic                     strt2_n,
    input  logic [DATA_W-ADDR_W-1:0] din_top,
    output logic                     viol
);

    logic any_strobe;
    logic bad_now;

    // Collect every misuse condition for this edge
    always_comb begin
        any_strobe = ~(strt1_n & strt2_n);
        bad_now    = (~load_n & any_strobe)
                   | (pend & any_strobe)
                   | (pend & ~load_n)
                   | (~load_n & ~(&din_top))
                   | (~strt1_n & ~strt2_n);
    end

    // Register the flag so it shows for the cycle after the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else begin
            viol <= bad_now;
        end
    end

endmodule

// File: rtl/sap_ptr_reg.sv
// The address pointer register and its next-value multiplexer.
// Assumes: src is decoded elsewhere; the increment wraps at 2**ADDR_W.
module sap_ptr_reg
    import sap_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_src_e          src,
    input  logic [ADDR_W-1:0] din_reg,
    input  logic [ADDR_W-1:0] start1,
    input  logic [ADDR_W-1:0] start2,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr_nxt;

    // Next pointer value by source
    always_comb begin
        case (src)
            SRC_DIN:  ptr_nxt = din_reg;
            SRC_BUF1: ptr_nxt = start1;
            SRC_BUF2: ptr_nxt = start2;
            SRC_INC:  ptr_nxt = ptr + STEP;
            SRC_EOB:  ptr_nxt = start1;
            default:  ptr_nxt = ptr;
        endcase
    end

    // Pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_nxt;
        end
    end

endmodule

// File: rtl/sap_pointer_ctrl.sv
// Sequential address pointer controller: one-cycle buffer-start jumps,
// a two-stage bus load through a data-in register, counting with wrap,
// an end-of-buffer return hook, data-ready and protocol-violation flags.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module sap_pointer_ctrl
    import sap_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              strt1_n,
    input  logic              strt2_n,
    input  logic              cnt_en,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] start1,
    input  logic [ADDR_W-1:0] start2,
    input  logic              eob_en,
    input  logic [ADDR_W-1:0] eob_addr,
    output logic [ADDR_W-1:0] ptr,
    output logic              data_ready,
    output logic              viol
);

    localparam int TOP_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] din_reg;
    logic              pend;
    logic              eob_hit;
    ptr_src_e          src;

    // End-of-buffer match on the current pointer
    always_comb begin
        eob_hit = eob_en && (ptr == eob_addr);
    end

    sap_load_stage #(.ADDR_W(ADDR_W)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .din_addr (din[ADDR_W-1:0]),
        .din_reg  (din_reg),
        .pend     (pend),
        .ready    (data_ready)
    );

    sap_src_select u_sel (
        .load_n  (load_n),
        .pend    (pend),
        .strt1_n (strt1_n),
        .strt2_n (strt2_n),
        .cnt_en  (cnt_en),
        .eob_hit (eob_hit),
        .src     (src)
    );

    sap_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .din_reg (din_reg),
        .start1  (start1),
        .start2  (start2),
        .ptr     (ptr)
    );

    sap_proto_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_proto (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .pend    (pend),
        .strt1_n (strt1_n),
        .strt2_n (strt2_n),
        .din_top (din[DATA_W-1:DATA_W-TOP_W]),
        .viol    (viol)
    );

endmodule

// File: rtl/sap_pointer_ctrl_chk.sv
// Checker for the pointer controller, observing only its ports. It keeps its
// own record of a pending bus load and of the captured address.
// Assumes: bound to sap_pointer_ctrl with default widths or matching overrides.
module sap_pointer_ctrl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              strt1_n,
    input logic              strt2_n,
    input logic              cnt_en,
    input logic [DATA_W-1:0] din,
    input logic [ADDR_W-1:0] start1,
    input logic [ADDR_W-1:0] start2,
    input logic              eob_en,
    input logic [ADDR_W-1:0] eob_addr,
    input logic [ADDR_W-1:0] ptr,
    input logic              data_ready,
    input logic              viol
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              pend_c;
    logic [ADDR_W-1:0] cap_c;

    // Observer copy of the bus-load protocol state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_c <= 1'b0;
            cap_c  <= '0;
        end else begin
            pend_c <= ~load_n;
            if (!load_n) begin
                cap_c <= din[ADDR_W-1:0];
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (ptr == '0 && !viol && !data_ready));

    // R2
    buf1_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!strt1_n && load_n) && !$past(pend_c))
        |-> ptr == $past(start1));

    // R4
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!load_n) && !$past(pend_c))
        |-> ptr == $past(ptr));

    // R4
    load_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pend_c)) |-> ptr == $past(cap_c));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pend_c)
         && $past(load_n && strt1_n && strt2_n && cnt_en && !eob_en))
        |-> ptr == $past(ptr) + ONE);

    // R6
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!load_n)) |-> !data_ready);

    // R7
    strobe_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!(strt1_n && strt2_n))
         && ($past(!load_n) || $past(pend_c))) |-> viol);

    // R9
    both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!strt1_n && !strt2_n)) |-> viol);

endmodule

bind sap_pointer_ctrl sap_pointer_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .strt1_n    (strt1_n),
    .strt2_n    (strt2_n),
    .cnt_en     (cnt_en),
    .din        (din),
    .start1     (start1),
    .start2     (start2),
    .eob_en     (eob_en),
    .eob_addr   (eob_addr),
    .ptr        (ptr),
    .data_ready (data_ready),
    .viol       (viol)
);

// File: tb/sap_pointer_ctrl_tb.sv
// Directed bench for sap_pointer_ctrl. Inputs change on the falling edge;
// outputs are checked on the falling edge after the rising edge under test.
module sap_pointer_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_n, strt1_n, strt2_n, cnt_en, eob_en;
    logic [15:0] din;
    logic [12:0] start1, start2, eob_addr;
    logic [12:0] ptr;
    logic        data_ready, viol;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sap_pointer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .strt1_n(strt1_n),
        .strt2_n(strt2_n), .cnt_en(cnt_en), .din(din), .start1(start1),
        .start2(start2), .eob_en(eob_en), .eob_addr(eob_addr), .ptr(ptr),
        .data_ready(data_ready), .viol(viol)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        load_n = 1'b1; strt1_n = 1'b1; strt2_n = 1'b1; cnt_en = 1'b0;
        din = 16'hE000;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); eob_en = 1'b0; eob_addr = '0;
        start1 = '0; start2 = '0;
        tick(); tick();
        chk("R1 ptr", ptr, 0); chk("R1 ready", data_ready, 0);
        chk("R1 viol", viol, 0);
        rst_n = 1'b1; tick();
        chk("R6 ready after reset", data_ready, 1);
        chk("R12 viol idle", viol, 0);
    endtask

    task automatic t_strobes();
        start1 = 13'h0123; start2 = 13'h1A00;
        strt1_n = 1'b0; tick(); idle();
        chk("R2 ptr", ptr, 'h0123); chk("R12 viol", viol, 0);
        chk("R6 ready", data_ready, 1);
        strt2_n = 1'b0; tick(); idle();
        chk("R3 ptr", ptr, 'h1A00);
    endtask

    task automatic t_count();
        cnt_en = 1'b1; tick(); tick(); tick();
        chk("R5 count", ptr, 'h1A03);
        cnt_en = 1'b0; tick();
        chk("R5 hold", ptr, 'h1A03);
        start1 = 13'h1FFE; strt1_n = 1'b0; tick(); idle();
        cnt_en = 1'b1; tick(); tick(); idle();
        chk("R5 wrap", ptr, 0);
    endtask

    task automatic t_busload();
        start1 = 13'h0040; strt1_n = 1'b0; tick(); idle();
        din = 16'hE000 | 16'h0ABC; load_n = 1'b0; cnt_en = 1'b1; tick();
        chk("R4 hold at capture", ptr, 'h0040);
        chk("R6 ready low", data_ready, 0); chk("R12 viol", viol, 0);
        load_n = 1'b1; din = 16'hFFFF; tick();
        chk("R4 landed", ptr, 'h0ABC); chk("R6 ready back", data_ready, 1);
        tick(); idle();
        chk("R5 count after load", ptr, 'h0ABD);
    endtask

    task automatic t_badtop();
        din = 16'h0555; load_n = 1'b0; tick(); idle();
        chk("R8 viol", viol, 1);
        tick();
        chk("R8 ptr low bits", ptr, 'h0555); chk("R12 viol clears", viol, 0);
    endtask

    task automatic t_conflict();
        start1 = 13'h0777; start2 = 13'h0888;
        din = 16'hE000 | 16'h0321; load_n = 1'b0; strt1_n = 1'b0; tick();
        chk("R7 viol in load", viol, 1); chk("R7 ptr held", ptr, 'h0555);
        load_n = 1'b1; strt1_n = 1'b1; strt2_n = 1'b0; tick(); idle();
        chk("R7 viol after load", viol, 1); chk("R7 load wins", ptr, 'h0321);
    endtask

    task automatic t_both();
        start1 = 13'h0111; start2 = 13'h0222;
        strt1_n = 1'b0; strt2_n = 1'b0; tick(); idle();
        chk("R9 ptr", ptr, 'h0111); chk("R9 viol", viol, 1);
    endtask

    task automatic t_eob();
        start1 = 13'h0050; start2 = 13'h00FF; eob_addr = 13'h0100;
        eob_en = 1'b1;
        strt2_n = 1'b0; tick(); idle();
        cnt_en = 1'b1; tick();
        chk("R10 reach end", ptr, 'h0100);
        tick();
        chk("R10 return", ptr, 'h0050);
        eob_en = 1'b0; strt2_n = 1'b0; cnt_en = 1'b0; tick(); idle();
        cnt_en = 1'b1; tick(); tick(); idle();
        chk("R10 disabled", ptr, 'h0101);
    endtask

    task automatic t_double();
        din = 16'hE000 | 16'h0AAA; load_n = 1'b0; tick();
        din = 16'hE000 | 16'h0BBB; tick();
        chk("R11 first lands", ptr, 'h0AAA); chk("R11 viol", viol, 1);
        chk("R11 ready", data_ready, 0);
        idle(); tick();
        chk("R11 second lands", ptr, 'h0BBB);
        chk("R11 ready back", data_ready, 1);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_strobes();
        t_count();
        t_busload();
        t_badtop();
        t_conflict();
        t_both();
        t_eob();
        t_double();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule